// File: doc/BRIEF.md
# Shader Flow-Control Sequencer

This block owns the program counter of a small vector shader core. Each cycle it presents an address to a combinational instruction-memory read port, inspects the returned word, and either steps to the next word, branches, or enters a nested scope. Arithmetic words are only stepped over; their execution belongs to other units. Two condition flags from the arithmetic side, a bank of sixteen boolean uniforms and a bank of integer uniforms steer the branching.

Scopes are kept on a small hardware stack. Each entry records where its body ends, where execution continues afterwards, a repeat count, a counter increment and the address a repeated body restarts at. No return word exists. When the program counter lands on the end address of the top entry, the sequencer spends one cycle closing or repeating that scope and then looks again. Subroutines, two-way conditional blocks and counted loops all use this one mechanism. The loop counter output is meant for indexed addressing in the datapath.

A start pulse launches a program at a given entry address. A stop word ends the program, and a one-cycle done pulse follows.

Top module: `sfc_sequencer`

## Requirements
- R1: After reset, and while idle without a start, `running`, `done` and `stack_ovf` are low and `loop_ctr` holds its value (zero after reset).
- R2: A start pulse while idle clears the stack and `stack_ovf`. The first fetch, on the next cycle, is at `main_pc`.
- R3: Word layout: opcode [31:27], combine mode [26:25], reference X [24], reference Y [23], uniform index [22:19], target [18:8], count [7:0]. Opcodes 0x00–0x0F, 0x10 (pass) and 0x1A–0x1F only step the fetch address by one.
- R4: Opcode 0x11 (stop) drops `running` and raises `done` for exactly one cycle, in the cycle after the stop word was fetched.
- R5: A condition holds when X matches `cond_x` and/or Y matches `cond_y`, by mode (0 either, 1 both, 2 X alone, 3 Y alone). Opcode 0x12 branches to the target when the condition holds and steps otherwise.
- R6: Opcode 0x13 branches to the target when the boolean uniform at the index is set, and steps otherwise.
- R7: Opcodes 0x14 (always), 0x15 (boolean uniform set) and 0x16 (condition holds) run `count` words from the target. Execution then resumes one past the calling word. When the gate is false, the word only steps.
- R8: Opcodes 0x17 (boolean uniform) and 0x18 (condition) pick one of two arms. True runs from the next word up to, but not including, the target. False runs `count` words from the target. Both arms then resume at target plus count.
- R9: Opcode 0x19 reads integer uniform `index mod 4` (x [7:0], y [15:8], z [23:16], entry k at bits 24k). It loads `loop_ctr` with y and runs the words from the next word through the target x+1 times, adding z to `loop_ctr` after each pass. It then resumes one past the target.
- R10: Reaching the end address of the top scope costs one cycle in which no word executes. Scopes ending at the same place close in consecutive cycles, and a word sitting at a closed scope's end executes only once no scope ends there.
- R11: A scope-opening word that finds `STACK_DEPTH` scopes open sets the sticky `stack_ovf`, changes nothing else, and only steps.
- R12: A start pulse while running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request, honoured only when idle |
| main_pc | input | 11 | Entry address for a launch |
| imem_addr | output | 11 | Instruction fetch address |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| cond_x | input | 1 | Condition flag X |
| cond_y | input | 1 | Condition flag Y |
| bool_unif | input | 16 | Boolean uniform bank |
| int_unif | input | 96 | Four integer uniforms of 24 bits each |
| loop_ctr | output | 8 | Loop counter |
| running | output | 1 | Program in progress |
| done | output | 1 | One-cycle pulse after a stop word |
| stack_ovf | output | 1 | Sticky scope-stack overflow |

## Verification
Closing a scope and executing a word can target the same cycle, because the word stored at a scope's end address is fetched at the moment that scope must close. The bench provokes this in three places. A loop whose exit address holds the stop word must close three passes before the stop acts. A false conditional arm resumes at its own end address. A conditional block nested in a subroutine ends, and the subroutine's end then follows straight away. Each case is judged by comparing the full fetch-address trace against a queue of expected addresses that includes every closing cycle. The bench also checks the final loop counter after the repeated closings.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int PC_W     = 11;
  localparam int CNT_W    = 8;
  localparam int UID_W    = 4;
  localparam int NUM_BOOL = 1 << UID_W;
  localparam int NUM_INT  = 4;
  localparam int INT_W    = 3 * CNT_W;
  localparam int WORD_W   = 32;

  typedef logic [PC_W-1:0]  pc_t;
  typedef logic [CNT_W-1:0] cnt_t;

  localparam logic [4:0] OPC_PASS     = 5'h10;
  localparam logic [4:0] OPC_STOP     = 5'h11;
  localparam logic [4:0] OPC_BR_COND  = 5'h12;
  localparam logic [4:0] OPC_BR_FLAG  = 5'h13;
  localparam logic [4:0] OPC_SUB      = 5'h14;
  localparam logic [4:0] OPC_SUB_FLAG = 5'h15;
  localparam logic [4:0] OPC_SUB_COND = 5'h16;
  localparam logic [4:0] OPC_SEL_FLAG = 5'h17;
  localparam logic [4:0] OPC_SEL_COND = 5'h18;
  localparam logic [4:0] OPC_REPEAT   = 5'h19;

  typedef enum logic [1:0] {CMB_ANY, CMB_ALL, CMB_X, CMB_Y} combine_e;

  typedef struct packed {
    logic [4:0]       op;
    logic [1:0]       mode;
    logic             refx;
    logic             refy;
    logic [UID_W-1:0] uid;
    pc_t              tgt;
    cnt_t             cnt;
  } instr_t;

  typedef struct packed {
    pc_t  stop_a;   // scope closes when the PC reaches this
    pc_t  back_a;   // continuation after the last pass
    pc_t  again_a;  // entry and restart address of the body
    cnt_t reps;     // passes still to run after the current one
    cnt_t step;     // added to the loop counter at each close
  } frame_t;

  function automatic pc_t pc_next(pc_t a);
    return a + pc_t'(1);
  endfunction

  function automatic pc_t pc_plus(pc_t a, cnt_t n);
    return a + {{(PC_W-CNT_W){1'b0}}, n};
  endfunction

  function automatic logic cond_hit(logic fx, logic fy, logic rx, logic ry, logic [1:0] mode);
    logic mx, my;
    mx = (fx == rx);
    my = (fy == ry);
    case (combine_e'(mode))
      CMB_ANY: return mx | my;
      CMB_ALL: return mx & my;
      CMB_X:   return mx;
      default: return my;
    endcase
  endfunction

  function automatic frame_t mk_frame(pc_t entry, pc_t stop, pc_t back, cnt_t reps, cnt_t step);
    frame_t f;
    f.again_a = entry;
    f.stop_a  = stop;
    f.back_a  = back;
    f.reps    = reps;
    f.step    = step;
    return f;
  endfunction
endpackage

// File: rtl/sfc_decode.sv
module sfc_decode import sfc_pkg::*; (
  input  logic [WORD_W-1:0]        word,
  input  pc_t                      pc,
  input  logic                     cond_x,
  input  logic                     cond_y,
  input  logic [NUM_BOOL-1:0]      bool_unif,
  input  logic [NUM_INT*INT_W-1:0] int_unif,
  output logic                     is_stop,
  output logic                     is_plain,
  output logic                     take_jump,
  output logic                     push_req,
  output logic                     lc_load,
  output cnt_t                     lc_val,
  output frame_t                   frame,
  output pc_t                      next_pc
);
  localparam int IDX_W = (NUM_INT > 1) ? $clog2(NUM_INT) : 1;

  instr_t            ins;
  logic              cond_ok;
  logic              flag_ok;
  logic              sel_ok;
  pc_t               pc1;
  logic [INT_W-1:0]  ibank [NUM_INT];
  logic [INT_W-1:0]  iu;

  for (genvar k = 0; k < NUM_INT; k++) begin : g_ibank
    assign ibank[k] = int_unif[k*INT_W +: INT_W];
  end

  assign ins     = instr_t'(word);
  assign pc1     = pc_next(pc);
  assign cond_ok = cond_hit(cond_x, cond_y, ins.refx, ins.refy, ins.mode);
  assign flag_ok = bool_unif[ins.uid];
  assign iu      = ibank[ins.uid[IDX_W-1:0]];
  assign sel_ok  = (ins.op == OPC_SEL_FLAG) ? flag_ok : cond_ok;
  assign lc_val  = iu[CNT_W +: CNT_W];

  always_comb begin
    is_stop   = 1'b0;
    is_plain  = 1'b0;
    take_jump = 1'b0;
    push_req  = 1'b0;
    lc_load   = 1'b0;
    next_pc   = pc1;
    frame     = mk_frame(ins.tgt, pc_plus(ins.tgt, ins.cnt), pc1, '0, '0);
    case (ins.op)
      OPC_STOP: is_stop = 1'b1;
      OPC_BR_COND: begin
        take_jump = cond_ok;
        if (cond_ok) next_pc = ins.tgt;
      end
      OPC_BR_FLAG: begin
        take_jump = flag_ok;
        if (flag_ok) next_pc = ins.tgt;
      end
      OPC_SUB:      push_req = 1'b1;
      OPC_SUB_FLAG: push_req = flag_ok;
      OPC_SUB_COND: push_req = cond_ok;
      OPC_SEL_FLAG, OPC_SEL_COND: begin
        push_req = 1'b1;
        if (sel_ok)
          frame = mk_frame(pc1, ins.tgt, pc_plus(ins.tgt, ins.cnt), '0, '0);
        else
          frame = mk_frame(ins.tgt, pc_plus(ins.tgt, ins.cnt),
                           pc_plus(ins.tgt, ins.cnt), '0, '0);
      end
      OPC_REPEAT: begin
        push_req = 1'b1;
        lc_load  = 1'b1;
        frame    = mk_frame(pc1, pc_next(ins.tgt), pc_next(ins.tgt),
                            iu[0 +: CNT_W], iu[2*CNT_W +: CNT_W]);
      end
      default: is_plain = 1'b1;
    endcase
  end
endmodule

// File: rtl/sfc_stack.sv
module sfc_stack import sfc_pkg::*; #(
  parameter int DEPTH = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear,
  input  logic   push,
  input  frame_t push_frame,
  input  logic   pop,
  input  logic   dec_top,
  output frame_t top_frame,
  output logic   empty,
  output logic   full
);
  localparam int SP_W = $clog2(DEPTH + 1);
  localparam int IX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SP_W-1:0] sp_q;
  logic [IX_W-1:0] top_ix;
  frame_t          slot_view [DEPTH];

  assign empty  = (sp_q == '0);
  assign full   = (sp_q == SP_W'(DEPTH));
  assign top_ix = IX_W'(sp_q - SP_W'(1));
  assign top_frame = empty ? '0 : slot_view[top_ix];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp_q <= '0;
    else if (clear)   sp_q <= '0;
    else if (push)    sp_q <= sp_q + SP_W'(1);
    else if (pop)     sp_q <= sp_q - SP_W'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    frame_t slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q <= '0;
      else if (push && sp_q == SP_W'(i))
        slot_q <= push_frame;
      else if (dec_top && sp_q == SP_W'(i + 1))
        slot_q.reps <= slot_q.reps - cnt_t'(1);
    end
    assign slot_view[i] = slot_q;
  end

  // R10: a close only ever acts on an open scope
  p_pop_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop || dec_top) |-> !empty);
  // R10: one close removes exactly one scope
  p_pop_depth_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clear) |=> sp_q == $past(sp_q) - SP_W'(1));
  // R11: the sequencer never pushes into a full stack
  p_push_room_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/sfc_sequencer.sv
module sfc_sequencer import sfc_pkg::*; #(
  parameter int STACK_DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [PC_W-1:0]          main_pc,
  output logic [PC_W-1:0]          imem_addr,
  input  logic [WORD_W-1:0]        imem_data,
  input  logic                     cond_x,
  input  logic                     cond_y,
  input  logic [NUM_BOOL-1:0]      bool_unif,
  input  logic [NUM_INT*INT_W-1:0] int_unif,
  output logic [CNT_W-1:0]         loop_ctr,
  output logic                     running,
  output logic                     done,
  output logic                     stack_ovf
);
  pc_t    pc_q;
  logic   run_q;
  frame_t top;
  logic   st_empty, st_full;

  logic   is_stop, is_plain, take_jump, push_req, lc_load;
  cnt_t   lc_val;
  frame_t frame;
  pc_t    next_pc;

  // named events for the assertions
  logic   start_go, resolve, pop_now, dec_now, exec, push_go, push_blk, stop_now;

  sfc_decode u_dec (
    .word(imem_data), .pc(pc_q), .cond_x(cond_x), .cond_y(cond_y),
    .bool_unif(bool_unif), .int_unif(int_unif),
    .is_stop(is_stop), .is_plain(is_plain), .take_jump(take_jump),
    .push_req(push_req), .lc_load(lc_load), .lc_val(lc_val),
    .frame(frame), .next_pc(next_pc)
  );

  sfc_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .clear(start_go), .push(push_go),
    .push_frame(frame), .pop(pop_now), .dec_top(dec_now),
    .top_frame(top), .empty(st_empty), .full(st_full)
  );

  assign start_go = start && !run_q;
  assign resolve  = run_q && !st_empty && (pc_q == top.stop_a);
  assign pop_now  = resolve && (top.reps == '0);
  assign dec_now  = resolve && (top.reps != '0);
  assign exec     = run_q && !resolve;
  assign push_go  = exec && push_req && !st_full;
  assign push_blk = exec && push_req && st_full;
  assign stop_now = exec && is_stop;

  assign imem_addr = pc_q;
  assign running   = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= '0;
      run_q     <= 1'b0;
      done      <= 1'b0;
      stack_ovf <= 1'b0;
      loop_ctr  <= '0;
    end else begin
      done <= 1'b0;
      if (start_go) begin
        pc_q      <= main_pc;
        run_q     <= 1'b1;
        stack_ovf <= 1'b0;
      end else if (resolve) begin
        loop_ctr <= loop_ctr + top.step;
        pc_q     <= pop_now ? top.back_a : top.again_a;
      end else if (stop_now) begin
        run_q <= 1'b0;
        done  <= 1'b1;
      end else if (push_go) begin
        pc_q <= frame.again_a;
        if (lc_load) loop_ctr <= lc_val;
      end else if (push_blk) begin
        stack_ovf <= 1'b1;
        pc_q      <= pc_next(pc_q);
      end else if (run_q) begin
        pc_q <= next_pc;
      end
    end
  end

  // R1: idle without a launch leaves the loop counter alone
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start) |=> $stable(loop_ctr));
  // R3: plain words step the fetch address by one
  p_plain_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && is_plain) |=> imem_addr == pc_next($past(pc_q)));
  // R4: done is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4: done only follows a running cycle that ended
  p_done_after_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!run_q && $past(run_q)));
  // R5: a taken branch lands on the decoded target
  p_branch_land_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && take_jump) |=> imem_addr == $past(next_pc));
  // R10: a close cycle never lets the word execute
  p_close_no_exec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resolve |=> run_q);
  // R11: the overflow flag only clears on a launch
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_ovf && !start_go) |=> stack_ovf);
  // R12: a start while running keeps the program going
  p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && start && !stop_now) |=> run_q);
endmodule

// File: tb/test_sfc_sequencer.sv
module test_sfc_sequencer;
  localparam logic [4:0] K_PASS = 5'h10, K_STOP = 5'h11, K_BRC = 5'h12, K_BRF = 5'h13;
  localparam logic [4:0] K_SUB = 5'h14, K_SUBF = 5'h15, K_SUBC = 5'h16;
  localparam logic [4:0] K_SELF = 5'h17, K_SELC = 5'h18, K_REP = 5'h19, K_ALU = 5'h01;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, cond_x, cond_y, running, done, stack_ovf;
  logic [10:0] main_pc, imem_addr;
  logic [31:0] imem_data;
  logic [15:0] bool_unif;
  logic [95:0] int_unif;
  logic [7:0]  loop_ctr;
  logic [31:0] rom [64];

  int    errs = 0, checks = 0, cyc = 0;
  int    exp_q[$];
  string cur_req = "R1";

  sfc_sequencer i_sfc_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .main_pc(main_pc),
    .imem_addr(imem_addr), .imem_data(imem_data), .cond_x(cond_x), .cond_y(cond_y),
    .bool_unif(bool_unif), .int_unif(int_unif), .loop_ctr(loop_ctr),
    .running(running), .done(done), .stack_ovf(stack_ovf)
  );

  always_comb imem_data = (imem_addr < 11'd64) ? rom[imem_addr[5:0]] : {K_STOP, 27'd0};

  function automatic logic [31:0] w(logic [4:0] op, int md, bit rx, bit ry, int uid, int tgt, int cnt);
    return {op, 2'(md), rx, ry, 4'(uid), 11'(tgt), 8'(cnt)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 64; i++) rom[i] = w(K_STOP, 0, 0, 0, 0, 0, 0);
  endtask

  // monitor: every running cycle pops one expected fetch address
  always @(negedge clk) begin
    if (rst_n && running) begin
      if (exp_q.size() == 0) chk(1'b0, cur_req, "extra fetch", int'(imem_addr), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(imem_addr) == e, cur_req, "fetch address", int'(imem_addr), e);
      end
    end
  end

  task automatic run(input int mpc, input bit poke, input int lc_exp, input bit ovf_exp, input string req);
    int guard;
    cur_req = req;
    @(negedge clk); main_pc = 11'(mpc); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin   // R12: launch request while running
      start = 1'b1; main_pc = 11'd40;
      @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    chk(done == 1'b1, "R4", {req, " done pulse"}, int'(done), 1);
    chk(running == 1'b0, "R4", {req, " stopped"}, int'(running), 0);
    chk(exp_q.size() == 0, req, "missing fetches", exp_q.size(), 0);
    chk(int'(loop_ctr) == lc_exp, req, "loop counter", int'(loop_ctr), lc_exp);
    chk(stack_ovf == ovf_exp, "R11", {req, " overflow flag"}, int'(stack_ovf), int'(ovf_exp));
    @(negedge clk);
    chk(done == 1'b0, "R4", {req, " done falls"}, int'(done), 0);
    exp_q.delete();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; errs++;
      $display("FAIL R4 watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; main_pc = '0; cond_x = 1'b1; cond_y = 1'b0;
    bool_unif = 16'h0004;
    int_unif = '0;
    int_unif[47:24] = {8'd3, 8'd10, 8'd2};   // entry 1: z=3 y=10 x=2
    clear_rom();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(running == 1'b0, "R1", "reset running", int'(running), 0);
    chk(done == 1'b0, "R1", "reset done", int'(done), 0);
    chk(loop_ctr == 8'd0, "R1", "reset loop counter", int'(loop_ctr), 0);
    chk(stack_ovf == 1'b0, "R1", "reset overflow", int'(stack_ovf), 0);

    // R2 R3: entry address and stepping words
    clear_rom();
    rom[5] = w(K_ALU, 0, 0, 0, 0, 60, 9);
    rom[6] = w(K_PASS, 0, 0, 0, 0, 60, 0);
    rom[7] = w(5'h1E, 0, 0, 0, 0, 60, 0);
    exp_q = '{5, 6, 7, 8};
    run(5, 0, 0, 0, "R2 R3");

    // R5: condition modes with cond_x=1 cond_y=0
    clear_rom();
    rom[0]  = w(K_BRC, 1, 1, 0, 0, 4, 0);   // both match -> 4
    rom[4]  = w(K_BRC, 1, 1, 1, 0, 20, 0);  // Y mismatches -> step
    rom[5]  = w(K_BRC, 0, 0, 1, 0, 20, 0);  // neither -> step
    rom[6]  = w(K_BRC, 3, 0, 0, 0, 10, 0);  // Y alone -> 10
    rom[10] = w(K_BRC, 2, 0, 0, 0, 20, 0);  // X alone fails -> step
    rom[11] = w(K_BRC, 0, 0, 0, 0, 14, 0);  // either -> 14
    exp_q = '{0, 4, 5, 6, 10, 11, 14};
    run(0, 0, 0, 0, "R5");

    // R6 R7: uniform branches and subroutines
    clear_rom();
    rom[0]  = w(K_BRF, 0, 0, 0, 3, 30, 0);
    rom[1]  = w(K_BRF, 0, 0, 0, 2, 3, 0);
    rom[3]  = w(K_SUB, 0, 0, 0, 0, 40, 2);
    rom[40] = w(K_ALU, 0, 0, 0, 0, 0, 0);
    rom[41] = w(K_ALU, 0, 0, 0, 0, 0, 0);
    rom[4]  = w(K_SUBF, 0, 0, 0, 3, 40, 2);
    rom[5]  = w(K_SUBC, 2, 1, 0, 0, 50, 1);
    rom[50] = w(K_ALU, 0, 0, 0, 0, 0, 0);
    exp_q = '{0, 1, 3, 40, 41, 42, 4, 5, 50, 51, 6};
    run(0, 0, 0, 0, "R6/R7");

    // R8: both arms of the two-way block
    clear_rom();
    rom[0] = w(K_SELF, 0, 0, 0, 2, 3, 2);
    rom[1] = w(K_ALU, 0, 0, 0, 0, 0, 0);
    rom[2] = w(K_ALU, 0, 0, 0, 0, 0, 0);
    rom[3] = w(K_ALU, 0, 0, 0, 0, 0, 0);
    rom[5] = w(K_SELC, 1, 0, 0, 0, 8, 1);
    rom[8] = w(K_ALU, 0, 0, 0, 0, 0, 0);
    exp_q = '{0, 1, 2, 3, 5, 8, 9, 9};
    run(0, 0, 0, 0, "R8");

    // R9: counted loop, stop word at the exit address
    clear_rom();
    rom[0] = w(K_REP, 0, 0, 0, 1, 2, 0);
    rom[1] = w(K_ALU, 0, 0, 0, 0, 0, 0);
    rom[2] = w(K_ALU, 0, 0, 0, 0, 0, 0);
    exp_q = '{0, 1, 2, 3, 1, 2, 3, 1, 2, 3, 3};
    run(0, 0, 19, 0, "R9");

    // R10: nested scopes closing back to back
    clear_rom();
    rom[0]  = w(K_SUB, 0, 0, 0, 0, 10, 4);
    rom[10] = w(K_SELF, 0, 0, 0, 2, 12, 2);
    rom[11] = w(K_ALU, 0, 0, 0, 0, 0, 0);
    rom[12] = w(K_ALU, 0, 0, 0, 0, 0, 0);
    rom[14] = w(K_ALU, 0, 0, 0, 0, 0, 0);
    exp_q = '{0, 10, 11, 12, 14, 1};
    run(0, 0, 19, 0, "R10");

    // R11: ninth open scope is refused
    clear_rom();
    for (int i = 0; i < 9; i++) rom[i] = w(K_SUB, 0, 0, 0, 0, i + 1, 50);
    exp_q = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9};
    run(0, 0, 19, 1, "R11");

    // R12 R2: launch ignored while running; new launch clears overflow
    clear_rom();
    rom[20] = w(K_ALU, 0, 0, 0, 0, 0, 0);
    rom[21] = w(K_ALU, 0, 0, 0, 0, 0, 0);
    rom[40] = w(K_ALU, 0, 0, 0, 0, 0, 0);
    exp_q = '{20, 21, 22};
    run(20, 1, 19, 0, "R12");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule